// File: doc/BRIEF.md
# Streaming BCH Parity Encoder and Checker for Flash Chunks

This block computes the parity of a shortened binary BCH code over one flash data chunk. Data bytes arrive one per cycle on a valid/ready input stream. They feed a byte-wide polynomial-division register whose feedback taps are the code's generator polynomial. That polynomial is not typed in by hand. Constant functions work it out at elaboration from three parameters: the chunk size, the correction strength and a primitive polynomial. The field order is chosen so that the field holds the chunk, and every code position ahead of the chunk is taken as zero. Those implicit zeros leave the division register unchanged, so they cost no cycles.

Bit order is mirrored at both ends. Each incoming byte is bit-reversed before it enters the division. Each outgoing parity byte is bit-reversed after it is taken from the remainder. In encode mode the parity bytes leave on a valid/ready output stream. In check mode the same number of stored parity bytes follow the chunk on the input stream instead. The block compares them with the recomputed parity and reports whether they agree.

Back-pressure rules are as follows. The input stream is stalled (`s_ready` low) only while parity bytes are being emitted. A held output byte keeps `m_valid` and `m_data` steady until `m_ready` takes it. The mode pin is a plain control pin, read once on the first byte of each chunk.

Top module: `bch_parity_gen`

## Requirements
- R1: In reset and on the first cycle after it, `s_ready` is 1 and `m_valid`, `done_o` and `chk_err_o` are all 0.
- R2: The field order M is the smallest integer with 2^M greater than 8*CHUNK_BYTES. The parity is T*M bits long and is sent as ceil(T*M/8) bytes: exactly that many, and no more, for each chunk.
- R3: The generator is the least common multiple of the minimal polynomials of alpha^1 to alpha^(2T). With 2-byte chunks, T=2 and primitive polynomial 0x25, it is 0x769 (bit i is the coefficient of x^i). In that setting the chunk 0x00,0x80 yields the parity bytes 0x5B,0x02.
- R4: Message bits enter highest degree first. Earlier bytes have higher degree. Within a byte, bit 0 enters first, because the byte is bit-reversed before division.
- R5: The remainder of message(x)*x^(T*M) mod g(x) is laid out with its most significant coefficient first and zero padding at the low end. It is cut into bytes, first byte from the top. Each byte is bit-reversed before it appears on `m_data`.
- R6: The division register restarts from zero on the first byte of every chunk, so a chunk's parity does not depend on earlier chunks or modes.
- R7: While `m_valid` is 1, `s_ready` is 0. While `m_valid` is 1 and `m_ready` is 0, `m_data` holds its value and `m_valid` stays 1 in the next cycle.
- R8: `done_o` is a one-cycle pulse. It appears in the cycle after the handshake of the last parity byte, whether that byte was emitted or, in check mode, consumed.
- R9: In check mode, the stored parity bytes use the same format as the emitted ones (R5). `chk_err_o` rises together with `done_o` when any stored byte differs and stays 0 when all match. It holds its value until the first byte of the next chunk is accepted, and clears in the cycle after that acceptance.
- R10: In check mode no byte is offered on the output stream (`m_valid` stays 0).
- R11: `verify_i` is sampled only on the first byte of a chunk. A change later in the chunk has no effect on that chunk's mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| verify_i | input | 1 | 1 = check stored parity, 0 = emit parity; read on the first byte of a chunk |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts an input byte |
| s_data | input | 8 | Data byte, or stored parity byte in check mode |
| m_valid | output | 1 | Parity byte valid |
| m_ready | input | 1 | Sink accepts the parity byte |
| m_data | output | 8 | Parity byte, bit-reversed |
| done_o | output | 1 | One-cycle pulse at the end of a chunk's parity phase |
| chk_err_o | output | 1 | Stored parity mismatch, held until the next chunk starts |

## Verification
The bench builds the block with 2-byte chunks, strength 2 and primitive polynomial 0x25. This gives a 5-bit field, a 10-bit parity padded to two bytes, and the generator 0x769. With those values a plain long division over a 26-bit codeword serves as the reference for every chunk. Such short chunks bring the padding path, the mid-chunk mode change and the per-byte mismatch check within reach in a few cycles each. The large default setting (1024 bytes, strength 24, polynomial 0x4443) is only elaborated, which exercises the generator derivation at full size.

// File: rtl/bch_pkg.sv
package bch_pkg;

  // Widest generator polynomial the derivation can hold (degree T*M).
  localparam int GMAX = 512;
  typedef logic [GMAX:0] gpoly_t;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_EMIT = 2'd1,
    ST_CHK  = 2'd2
  } bch_state_e;

  // Smallest m such that 2^m exceeds the number of protected bits.
  function automatic int field_order(input int bits);
    int m;
    m = 1;
    for (int k = 0; k < 30; k++) begin
      if ((1 << m) <= bits) m = m + 1;
    end
    return m;
  endfunction

  // Multiply two field elements modulo the primitive polynomial.
  function automatic int gf_mul(input int a, input int b, input int m, input int prim);
    int r;
    r = 0;
    for (int k = m - 1; k >= 0; k--) begin
      r = r << 1;
      if (((r >> m) & 1) != 0) r = r ^ prim;
      if (((b >> k) & 1) != 0) r = r ^ a;
    end
    return r;
  endfunction

  // alpha^e by square and multiply, alpha being the element 2.
  function automatic int gf_pow(input int e, input int m, input int prim);
    int r;
    int b;
    r = 1;
    b = 2;
    for (int k = 0; k < 31; k++) begin
      if (((e >> k) & 1) != 0) r = gf_mul(r, b, m, prim);
      b = gf_mul(b, b, m, prim);
    end
    return r;
  endfunction

  // Product of the distinct minimal polynomials of alpha^1 .. alpha^(2t).
  function automatic gpoly_t gen_poly(input int m, input int t, input int prim);
    gpoly_t g;
    gpoly_t acc;
    int     n;
    int     e;
    int     beta;
    int     c[17];
    bit     rep;
    bit     fin;
    g = '0;
    g[0] = 1'b1;
    n = (1 << m) - 1;
    for (int i = 1; i <= 2 * t; i += 2) begin
      // Only the smallest member of a cyclotomic coset contributes.
      rep = 1'b1;
      e = i;
      for (int k = 0; k < m; k++) begin
        e = (e * 2) % n;
        if (e < i) rep = 1'b0;
      end
      if (rep) begin
        for (int j = 0; j < 17; j++) c[j] = 0;
        c[0] = 1;
        e = i;
        fin = 1'b0;
        for (int k = 0; k < m; k++) begin
          if (!fin) begin
            beta = gf_pow(e, m, prim);
            for (int j = 16; j >= 0; j--) begin
              if (j > 0) c[j] = c[j-1] ^ gf_mul(c[j], beta, m, prim);
              else       c[j] = gf_mul(c[j], beta, m, prim);
            end
            e = (e * 2) % n;
            if (e == i) fin = 1'b1;
          end
        end
        acc = '0;
        for (int j = 0; j < 17; j++) begin
          if ((c[j] & 1) != 0) acc = acc ^ (g << j);
        end
        g = acc;
      end
    end
    return g;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/bch_lfsr_byte.sv
module bch_lfsr_byte import bch_pkg::*; #(
  parameter int           P     = 10,
  parameter logic [P-1:0] GPOLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [7:0]   din,
  output logic [P-1:0] rem_nxt
);

  logic [P-1:0] rem_q;
  logic [P-1:0] work;
  logic [7:0]   rv;
  logic         fb;

  // Eight division steps per byte; the reversed byte enters from its top bit.
  always_comb begin
    work = start ? '0 : rem_q;
    rv   = rev8(din);
    fb   = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      fb   = rv[i] ^ work[P-1];
      work = {work[P-2:0], 1'b0} ^ (fb ? GPOLY : '0);
    end
    rem_nxt = work;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rem_q <= '0;
    else if (en) rem_q <= rem_nxt;
  end

endmodule

// File: rtl/bch_par_ser.sv
module bch_par_ser import bch_pkg::*; #(
  parameter int P  = 10,
  parameter int NB = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [P-1:0] rem_i,
  output logic [7:0]   byte_o
);

  localparam int PADW = NB * 8;

  logic [PADW-1:0] sh_q;

  // Remainder sits at the top, padding zeros fill the low end.
  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= PADW'(rem_i) << (PADW - P);
    else if (shift) sh_q <= sh_q << 8;
  end

  assign byte_o = rev8(sh_q[PADW-1 -: 8]);

endmodule

// File: rtl/bch_ctrl.sv
module bch_ctrl import bch_pkg::*; #(
  parameter int CHUNK_BYTES = 2,
  parameter int NB          = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       verify_i,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  output logic       m_valid,
  input  logic       m_ready,
  input  logic [7:0] exp_byte,
  output logic       lfsr_en,
  output logic       lfsr_start,
  output logic       ser_load,
  output logic       ser_shift,
  output logic       verify_q,
  output logic       done_o,
  output logic       chk_err_o
);

  localparam int DW = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  bch_state_e    st_q;
  logic [DW-1:0] dcnt_q;
  logic [PW-1:0] pcnt_q;
  logic          acc_q;
  logic          s_fire;
  logic          m_fire;
  logic          first_beat;
  logic          last_data;
  logic          last_par;
  logic          mism;
  logic          mode_now;

  assign s_ready    = (st_q != ST_EMIT);
  assign m_valid    = (st_q == ST_EMIT);
  assign s_fire     = s_valid && s_ready;
  assign m_fire     = m_valid && m_ready;
  assign first_beat = (st_q == ST_DATA) && (dcnt_q == '0);
  assign last_data  = (dcnt_q == DW'(CHUNK_BYTES - 1));
  assign last_par   = (pcnt_q == PW'(NB - 1));
  assign mism       = (s_data != exp_byte);
  assign mode_now   = first_beat ? verify_i : verify_q;

  assign lfsr_en    = s_fire && (st_q == ST_DATA);
  assign lfsr_start = first_beat;
  assign ser_load   = lfsr_en && last_data;
  assign ser_shift  = m_fire || (s_fire && (st_q == ST_CHK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_DATA;
      dcnt_q    <= '0;
      pcnt_q    <= '0;
      acc_q     <= 1'b0;
      verify_q  <= 1'b0;
      done_o    <= 1'b0;
      chk_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_DATA: begin
          if (s_fire) begin
            if (first_beat) begin
              verify_q  <= verify_i;
              chk_err_o <= 1'b0;
              acc_q     <= 1'b0;
            end
            if (last_data) begin
              dcnt_q <= '0;
              pcnt_q <= '0;
              st_q   <= mode_now ? ST_CHK : ST_EMIT;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
        end
        ST_EMIT: begin
          if (m_fire) begin
            if (last_par) begin
              st_q   <= ST_DATA;
              done_o <= 1'b1;
            end else begin
              pcnt_q <= pcnt_q + 1'b1;
            end
          end
        end
        ST_CHK: begin
          if (s_fire) begin
            if (last_par) begin
              st_q      <= ST_DATA;
              done_o    <= 1'b1;
              chk_err_o <= acc_q | mism;
            end else begin
              acc_q  <= acc_q | mism;
              pcnt_q <= pcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

endmodule

// File: rtl/bch_parity_gen.sv
module bch_parity_gen import bch_pkg::*; #(
  parameter int          CHUNK_BYTES = 1024,
  parameter int          T           = 24,
  parameter logic [31:0] PRIM        = 32'h4443
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       verify_i,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       done_o,
  output logic       chk_err_o
);

  localparam int           DATA_BITS = CHUNK_BYTES * 8;
  localparam int           M         = field_order(DATA_BITS);
  localparam int           P         = T * M;
  localparam int           NB        = (P + 7) / 8;
  localparam gpoly_t       GFULL     = gen_poly(M, T, int'(PRIM));
  localparam logic [P-1:0] GPOLY     = GFULL[P-1:0];

  logic         lfsr_en;
  logic         lfsr_start;
  logic         ser_load;
  logic         ser_shift;
  logic         verify_q;
  logic [P-1:0] rem_nxt;
  logic [7:0]   par_byte;

  bch_lfsr_byte #(.P(P), .GPOLY(GPOLY)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (lfsr_en),
    .start   (lfsr_start),
    .din     (s_data),
    .rem_nxt (rem_nxt)
  );

  bch_par_ser #(.P(P), .NB(NB)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ser_load),
    .shift  (ser_shift),
    .rem_i  (rem_nxt),
    .byte_o (par_byte)
  );

  bch_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .NB(NB)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .verify_i   (verify_i),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .exp_byte   (par_byte),
    .lfsr_en    (lfsr_en),
    .lfsr_start (lfsr_start),
    .ser_load   (ser_load),
    .ser_shift  (ser_shift),
    .verify_q   (verify_q),
    .done_o     (done_o),
    .chk_err_o  (chk_err_o)
  );

  assign m_data = par_byte;

endmodule

// File: rtl/bch_parity_gen_chk.sv
module bch_parity_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       done_o,
  input logic       chk_err_o,
  input logic       verify_q
);

  // R7: a stalled output byte stays offered and unchanged
  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R7: no input is taken while parity is offered
  a_r7_input_gated: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  // R8: completion lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: check mode keeps the output stream silent
  a_r10_check_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    verify_q |-> !m_valid);

  // R9: a mismatch is reported only at the end of a chunk
  a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_err_o) |-> done_o);

endmodule

bind bch_parity_gen bch_parity_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .done_o    (done_o),
  .chk_err_o (chk_err_o),
  .verify_q  (verify_q)
);

// File: tb/sim_bch_parity_gen.sv
module sim_bch_parity_gen;

  localparam int          CB  = 2;
  localparam int          TT  = 2;
  localparam logic [31:0] PR  = 32'h25;
  localparam logic [10:0] GEN = 11'h769;   // R3: generator for this setting

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       verify_i = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       m_ready = 1'b1;
  logic       s_ready;
  logic       m_valid;
  logic [7:0] m_data;
  logic       done_o;
  logic       chk_err_o;

  always #5 clk = ~clk;

  bch_parity_gen #(.CHUNK_BYTES(CB), .T(TT), .PRIM(PR)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .verify_i  (verify_i),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .done_o    (done_o),
    .chk_err_o (chk_err_o)
  );

  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         stall_en = 1'b0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] rv(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // R4/R5 reference: long division of the 26-bit codeword by the generator.
  function automatic logic [15:0] ref_par(input logic [7:0] b0, input logic [7:0] b1);
    logic [25:0] c;
    logic [15:0] pv;
    c = {rv(b0), rv(b1), 10'b0};
    for (int i = 25; i >= 10; i--) begin
      if (c[i]) c = c ^ (26'(GEN) << (i - 10));
    end
    pv = {c[9:0], 6'b0};
    return {rv(pv[15:8]), rv(pv[7:0])};
  endfunction

  // Monitor: pops expected parity bytes as the design hands them over.
  always @(negedge clk) begin
    logic [7:0] e;
    cyc++;
    m_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
    if (rst_n && m_valid) begin
      check(!s_ready, "R7", "s_ready during emission", int'(s_ready), 0);
      if (m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected parity byte", int'(m_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(m_data == e, "R5", "parity byte", int'(m_data), int'(e));
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    bit rd;
    s_valid = 1'b1;
    s_data  = b;
    forever begin
      rd = s_ready;
      @(negedge clk);
      if (rd) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done_o && k < 40) begin
      @(negedge clk);
      k++;
    end
    check(done_o, "R8", "done after last parity byte", int'(done_o), 1);
    check(exp_q.size() == 0, "R2", "parity bytes outstanding", exp_q.size(), 0);
    @(negedge clk);
    check(!done_o, "R8", "done width", int'(done_o), 0);
    check(!m_valid, "R2", "extra parity byte offered", int'(m_valid), 0);
  endtask

  task automatic enc_chunk(input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] p;
    p = ref_par(b0, b1);
    exp_q.push_back(p[15:8]);
    exp_q.push_back(p[7:0]);
    verify_i = 1'b0;
    send_byte(b0);
    send_byte(b1);
    wait_done();
  endtask

  task automatic chk_chunk(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] p0, input logic [7:0] p1,
                           input bit exp_err);
    verify_i = 1'b1;
    send_byte(b0);
    send_byte(b1);
    send_byte(p0);
    send_byte(p1);
    check(done_o, "R8", "done after stored parity", int'(done_o), 1);
    check(chk_err_o == exp_err, "R9", "mismatch flag", int'(chk_err_o), int'(exp_err));
    repeat (3) @(negedge clk);
    check(chk_err_o == exp_err, "R9", "flag held", int'(chk_err_o), int'(exp_err));
    check(!done_o, "R8", "no repeated done", int'(done_o), 0);
    verify_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] p;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    check(s_ready, "R1", "s_ready in reset", int'(s_ready), 1);
    check(!m_valid && !done_o && !chk_err_o, "R1", "outputs in reset",
          int'({m_valid, done_o, chk_err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready && !m_valid, "R1", "idle after reset",
          int'({s_ready, m_valid}), 2);

    // R3: single lowest-degree message bit gives the generator remainder
    exp_q.push_back(8'h5B);
    exp_q.push_back(8'h02);
    verify_i = 1'b0;
    send_byte(8'h00);
    send_byte(8'h80);
    wait_done();

    // R5: all-zero chunk gives all-zero parity
    enc_chunk(8'h00, 8'h00);
    // R4: bit 0 of a byte is its highest-degree bit
    enc_chunk(8'h01, 8'h00);
    enc_chunk(8'h80, 8'h00);
    enc_chunk(8'h00, 8'h01);

    // R6/R7: back-to-back chunks with a stalling sink
    stall_en = 1'b1;
    enc_chunk(8'hFF, 8'hFF);
    enc_chunk(8'hA5, 8'h3C);
    enc_chunk(8'h12, 8'h34);
    enc_chunk(8'h12, 8'h34);
    stall_en = 1'b0;

    // R11: mode change after the first byte is ignored
    p = ref_par(8'h5A, 8'hC3);
    exp_q.push_back(p[15:8]);
    exp_q.push_back(p[7:0]);
    verify_i = 1'b0;
    send_byte(8'h5A);
    verify_i = 1'b1;
    send_byte(8'hC3);
    verify_i = 1'b0;
    wait_done();

    // R9/R10: matching stored parity
    p = ref_par(8'hA5, 8'h3C);
    chk_chunk(8'hA5, 8'h3C, p[15:8], p[7:0], 1'b0);
    // R9: one flipped bit in the padded byte, then in the first byte
    chk_chunk(8'hA5, 8'h3C, p[15:8], p[7:0] ^ 8'h80, 1'b1);
    chk_chunk(8'hA5, 8'h3C, p[15:8] ^ 8'h01, p[7:0], 1'b1);

    // R9: flag clears once the next chunk's first byte is taken
    p = ref_par(8'h77, 8'h10);
    exp_q.push_back(p[15:8]);
    exp_q.push_back(p[7:0]);
    verify_i = 1'b0;
    send_byte(8'h77);
    check(!chk_err_o, "R9", "flag cleared by next chunk", int'(chk_err_o), 0);
    send_byte(8'h10);
    wait_done();

    // R11: check mode chosen on the first byte survives a later change
    p = ref_par(8'h3E, 8'h81);
    verify_i = 1'b1;
    send_byte(8'h3E);
    verify_i = 1'b0;
    send_byte(8'h81);
    send_byte(p[15:8]);
    send_byte(p[7:0]);
    check(done_o && !chk_err_o, "R11", "check mode kept",
          int'({done_o, chk_err_o}), 2);

    // R6: encode after check mode starts clean
    repeat (2) @(negedge clk);
    enc_chunk(8'hC0, 8'hDE);

    finish_run();
  end

endmodule